// File: doc/BRIEF.md
# Compression Engine Host Register Port

This block is the host-facing register port of a video compression engine. The host sees only four 32-bit registers, selected by a 2-bit address and accessed with active-low chip select, read and write strobes. Through them it reaches three things: a bank of sixteen 32-bit control and status words, a 512-word by 32-bit compressed-data FIFO, and a split interrupt register that holds 16 enable bits and 16 cause bits.

The control words are never mapped directly. The host first writes a word index into a pointer register, then reads or writes a data window that acts on the word the pointer names. The FIFO appears as a single data register. A host read pops one word, which is the encoding direction: the engine pushes and the host drains. A host write pushes one word, which is the decoding direction: the host fills and the engine pops. The engine side has a push port and a show-ahead pop port. If the host and the engine use the same FIFO port in the same cycle, the host access wins and the engine request is refused for that cycle.

Every access is acknowledged on an active-low handshake line. The host must keep its strobe asserted until the acknowledge appears, and it must release the strobe before it starts the next access. An active-high interrupt line tells the host when the FIFO has filled to a level it programmed, or when the engine lost a word because the FIFO was full.

Top module: `cmpHostIf`

## Requirements
- R1: Host address 2'b00 selects the pointer register, which is fully readable and writable. 2'b01 selects the indirect data window, 2'b10 the FIFO data register, and 2'b11 the interrupt register.
- R2: A write to the data window stores into the bank word whose index is held in the pointer, and a read of the window returns that word. Indices 0 to 15 are valid.
- R3: When the pointer holds a value of 16 or more, a read of the data window returns zero and a write changes no bank word.
- R4: Bank word 0 holds the FIFO fill threshold in bits 9:0 and resets to zero. Bank word 1 reads back the current FIFO occupancy (0 to 512), and writes to it are ignored.
- R5: A host read of the FIFO register pops the oldest word, and a host write pushes a word. The engine push and pop ports use the same FIFO in first-in, first-out order. engFull and engEmpty report a full and an empty FIFO.
- R6: For an accepted access, hostAckN goes low at the first clock edge that sees chip select plus exactly one strobe. Read data is valid from that point. hostAckN stays low until the strobe or chip select is released, and it returns high at the next edge.
- R7: A host FIFO read while the FIFO is empty, or a host FIFO write while it is full, leaves hostAckN high and changes neither the occupancy nor the read order.
- R8: Status bit 0 (register bit 0) is set on every clock where the threshold is nonzero and the occupancy is at or above it.
- R9: An engine push that is refused, because the FIFO is full or the host pushes in the same cycle, sets status bit 1 (register bit 1). engPushOk is low while the FIFO is full.
- R10: Writing the interrupt register with a 1 in a status bit clears that bit, unless its set condition holds in the same cycle. A 0 leaves the bit unchanged. Unimplemented status bits read zero.
- R11: Register bits 31:16 are enable bits that the host writes and reads back. irq is high exactly when some status bit and its enable (status bit n paired with register bit n+16) are both set.
- R12: An access with both strobes low is refused: hostAckN stays high and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Chip select, active low |
| hostRdN | input | 1 | Read strobe, active low |
| hostWrN | input | 1 | Write strobe, active low |
| hostAddr | input | 2 | Direct register select |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid while acknowledged |
| hostAckN | output | 1 | Access accepted, active low |
| irq | output | 1 | Interrupt to host, active high |
| engPush | input | 1 | Engine push request |
| engPushData | input | 32 | Engine push word |
| engPushOk | output | 1 | Engine push taken this cycle |
| engPop | input | 1 | Engine pop request |
| engPopData | output | 32 | Oldest FIFO word (show-ahead) |
| engPopOk | output | 1 | Engine pop taken this cycle |
| engFull | output | 1 | FIFO holds 512 words |
| engEmpty | output | 1 | FIFO holds no words |

## Verification
The bench fills the FIFO to exactly 512 words and then tries both a host push and an engine push. A design that counted the level wrongly would acknowledge the push or overwrite the oldest word, and a design that lost the overflow cause would leave status bit 1 clear. It reads from an empty FIFO and expects no acknowledge and an unchanged read order; a design that popped anyway would move the pointer and skip a word later. It sets the threshold at four words and checks that the cause bit stays clear at three and sets at four. It then checks that write-one-to-clear works, and that a cleared enable silences the interrupt while the cause stays visible. A design with an off-by-one compare, or one that cleared the bit on any write, fails these checks. It also sends an out-of-range pointer, a write to the read-only level word and a dual-strobe access, and it expects each of them to leave the state unchanged.

// File: rtl/cmpHostPkg.sv
package cmpHostPkg;

  // Direct register select; the encoding is the host-visible address map.
  typedef enum logic [1:0] {
    SEL_PTR  = 2'b00,
    SEL_WIN  = 2'b01,
    SEL_FIFO = 2'b10,
    SEL_IRQ  = 2'b11
  } hostSel_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic     capture;   // latch read data for selected register
    hostSel_e sel;
    logic     wrPtr;
    logic     wrWin;
    logic     push;
    logic     pop;
    logic     wrIrq;
  } hostStb_t;

  localparam int IDX_THRESH = 0;
  localparam int IDX_LEVEL  = 1;
  localparam int STAT_THRESH = 0;
  localparam int STAT_OVFL   = 1;

endpackage

// File: rtl/cmpFifo.sv
module cmpFifo #(
  parameter int DEPTH = 512,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic          doPush;
  logic          doPop;

  assign full   = (level == LW'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/cmpHostCtrl.sv
module cmpHostCtrl
  import cmpHostPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostCsN,
  input  logic     hostRdN,
  input  logic     hostWrN,
  input  logic [1:0] hostAddr,
  input  logic     fifoEmpty,
  input  logic     fifoFull,
  output hostStb_t stb,
  output logic     hostAckN
);

  typedef enum logic {ST_IDLE, ST_HOLD} ctrlState_e;

  ctrlState_e state;
  logic       rdReq;
  logic       wrReq;
  logic       anyReq;
  logic       start;
  logic       accessOk;
  hostSel_e   sel;

  assign sel    = hostSel_e'(hostAddr);
  assign rdReq  = !hostCsN && !hostRdN &&  hostWrN;
  assign wrReq  = !hostCsN &&  hostRdN && !hostWrN;
  assign anyReq = rdReq || wrReq;
  assign start  = (state == ST_IDLE) && anyReq;

  always_comb begin
    accessOk = 1'b1;
    if (sel == SEL_FIFO) accessOk = rdReq ? !fifoEmpty : !fifoFull;
  end

  always_comb begin
    stb         = '0;
    stb.sel     = sel;
    if (start && accessOk) begin
      stb.capture = rdReq;
      stb.wrPtr   = wrReq && (sel == SEL_PTR);
      stb.wrWin   = wrReq && (sel == SEL_WIN);
      stb.wrIrq   = wrReq && (sel == SEL_IRQ);
      stb.push    = wrReq && (sel == SEL_FIFO);
      stb.pop     = rdReq && (sel == SEL_FIFO);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      hostAckN <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (anyReq) begin
          state    <= ST_HOLD;
          hostAckN <= !accessOk;
        end
        ST_HOLD: if (!anyReq) begin
          state    <= ST_IDLE;
          hostAckN <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmpHostData.sv
module cmpHostData
  import cmpHostPkg::*;
#(
  parameter int W       = 32,
  parameter int NUM_IND = 16,
  parameter int DEPTH   = 512,
  localparam int IW     = $clog2(NUM_IND),
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int SW     = W / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  hostStb_t      stb,
  input  logic [W-1:0]  hostWdata,
  output logic [W-1:0]  hostRdata,
  output logic          irq,
  input  logic          engPush,
  input  logic [W-1:0]  engPushData,
  output logic          engPushOk,
  input  logic          engPop,
  output logic [W-1:0]  engPopData,
  output logic          engPopOk,
  output logic          fifoFull,
  output logic          fifoEmpty,
  output logic [LW-1:0] fifoLevel,
  output logic [LW-1:0] thresh,
  output logic [SW-1:0] statusQ
);

  localparam logic [SW-1:0] STAT_IMPL = SW'((1 << (STAT_OVFL + 1)) - 1);

  logic [W-1:0]  ptrQ;
  logic [W-1:0]  bankQ [NUM_IND];
  logic [SW-1:0] enableQ;
  logic [SW-1:0] setVec;
  logic [SW-1:0] clrVec;
  logic          ptrInRange;
  logic [IW-1:0] ptrIdx;
  logic [W-1:0]  winRead;
  logic          fifoPush;
  logic          fifoPop;
  logic [W-1:0]  fifoPushData;

  // ---- FIFO sharing: host strobe wins over engine request ----
  assign engPushOk    = engPush && !fifoFull && !stb.push;
  assign engPopOk     = engPop && !fifoEmpty && !stb.pop;
  assign fifoPush     = stb.push || engPushOk;
  assign fifoPop      = stb.pop || engPopOk;
  assign fifoPushData = stb.push ? hostWdata : engPushData;

  cmpFifo #(.DEPTH(DEPTH), .W(W)) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fifoPush),
    .pushData (fifoPushData),
    .pop      (fifoPop),
    .head     (engPopData),
    .level    (fifoLevel),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  // ---- Indirect bank ----
  assign ptrIdx     = ptrQ[IW-1:0];
  assign ptrInRange = (ptrQ[W-1:IW] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ptrQ <= '0;
    else if (stb.wrPtr) ptrQ <= hostWdata;
  end

  for (genvar gi = 0; gi < NUM_IND; gi++) begin : g_bank
    if (gi == IDX_LEVEL) begin : g_level
      assign bankQ[gi] = {{(W - LW){1'b0}}, fifoLevel};
    end else begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          bankQ[gi] <= '0;
        else if (stb.wrWin && ptrInRange && (ptrIdx == IW'(gi)))
          bankQ[gi] <= hostWdata;
      end
    end
  end

  assign thresh  = bankQ[IDX_THRESH][LW-1:0];
  assign winRead = ptrInRange ? bankQ[ptrIdx] : '0;

  // ---- Interrupt causes and enables ----
  always_comb begin
    setVec              = '0;
    setVec[STAT_THRESH] = (thresh != '0) && (fifoLevel >= thresh);
    setVec[STAT_OVFL]   = engPush && !engPushOk;
    clrVec              = stb.wrIrq ? hostWdata[SW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= ((statusQ & ~clrVec) | setVec) & STAT_IMPL;
      if (stb.wrIrq) enableQ <= hostWdata[W-1:SW];
    end
  end

  assign irq = |(statusQ & enableQ);

  // ---- Read data capture ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdata <= '0;
    else if (stb.capture) begin
      case (stb.sel)
        SEL_PTR:  hostRdata <= ptrQ;
        SEL_WIN:  hostRdata <= winRead;
        SEL_FIFO: hostRdata <= engPopData;
        SEL_IRQ:  hostRdata <= {enableQ, statusQ};
        default:  hostRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cmpHostIf.sv
module cmpHostIf
  import cmpHostPkg::*;
#(
  parameter int W       = 32,
  parameter int NUM_IND = 16,
  parameter int DEPTH   = 512,
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int SW     = W / 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostCsN,
  input  logic         hostRdN,
  input  logic         hostWrN,
  input  logic [1:0]   hostAddr,
  input  logic [W-1:0] hostWdata,
  output logic [W-1:0] hostRdata,
  output logic         hostAckN,
  output logic         irq,
  input  logic         engPush,
  input  logic [W-1:0] engPushData,
  output logic         engPushOk,
  input  logic         engPop,
  output logic [W-1:0] engPopData,
  output logic         engPopOk,
  output logic         engFull,
  output logic         engEmpty
);

  hostStb_t      stb;
  logic [LW-1:0] fifoLevel;
  logic [LW-1:0] thresh;
  logic [SW-1:0] statusQ;

  cmpHostCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostCsN   (hostCsN),
    .hostRdN   (hostRdN),
    .hostWrN   (hostWrN),
    .hostAddr  (hostAddr),
    .fifoEmpty (engEmpty),
    .fifoFull  (engFull),
    .stb       (stb),
    .hostAckN  (hostAckN)
  );

  cmpHostData #(.W(W), .NUM_IND(NUM_IND), .DEPTH(DEPTH)) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .hostWdata   (hostWdata),
    .hostRdata   (hostRdata),
    .irq         (irq),
    .engPush     (engPush),
    .engPushData (engPushData),
    .engPushOk   (engPushOk),
    .engPop      (engPop),
    .engPopData  (engPopData),
    .engPopOk    (engPopOk),
    .fifoFull    (engFull),
    .fifoEmpty   (engEmpty),
    .fifoLevel   (fifoLevel),
    .thresh      (thresh),
    .statusQ     (statusQ)
  );

endmodule

// File: rtl/cmpHostChk.sv
module cmpHostChk #(
  parameter int DEPTH = 512,
  parameter int LW    = 10,
  parameter int SW    = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostCsN,
  input logic          hostRdN,
  input logic          hostWrN,
  input logic          hostAckN,
  input logic          engPush,
  input logic          engPushOk,
  input logic          engFull,
  input logic          engEmpty,
  input logic [LW-1:0] fifoLevel,
  input logic [LW-1:0] thresh,
  input logic [SW-1:0] statusQ
);

  // R6: acknowledge only follows a cycle with chip select and exactly one strobe
  a_r6_ack_after_request: assert property (@(posedge clk) disable iff (!rstN)
    !hostAckN |-> $past(!hostCsN && (hostRdN != hostWrN)));

  // R12: both strobes low never leads to an acknowledge
  a_r12_dual_strobe_refused: assert property (@(posedge clk) disable iff (!rstN)
    (!hostCsN && !hostRdN && !hostWrN) |=> hostAckN);

  // R8: threshold reached sets cause bit 0
  a_r8_threshold_cause: assert property (@(posedge clk) disable iff (!rstN)
    ((thresh != '0) && (fifoLevel >= thresh)) |=> statusQ[0]);

  // R9: no engine push is taken while full
  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    engFull |-> !engPushOk);

  // R9: a refused engine push records the overflow cause
  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    (engPush && !engPushOk) |=> statusQ[1]);

  // R5: occupancy stays in range and moves by at most one word per cycle
  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LW'(DEPTH));

  a_r5_level_step: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == $past(fifoLevel)) || (fifoLevel == $past(fifoLevel) + 1'b1) ||
    (fifoLevel == $past(fifoLevel) - 1'b1));

  a_r5_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(engFull && engEmpty));

endmodule

bind cmpHostIf cmpHostChk #(.DEPTH(DEPTH), .LW(LW), .SW(SW)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostCsN   (hostCsN),
  .hostRdN   (hostRdN),
  .hostWrN   (hostWrN),
  .hostAckN  (hostAckN),
  .engPush   (engPush),
  .engPushOk (engPushOk),
  .engFull   (engFull),
  .engEmpty  (engEmpty),
  .fifoLevel (fifoLevel),
  .thresh    (thresh),
  .statusQ   (statusQ)
);

// File: tb/test_cmpHostIf.sv
`timescale 1ns/1ps
module test_cmpHostIf;

  localparam int DEPTH = 512;
  localparam logic [1:0] A_PTR = 2'b00, A_WIN = 2'b01, A_FIFO = 2'b10, A_IRQ = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [1:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostAckN, irq;
  logic        engPush = 1'b0, engPop = 1'b0;
  logic [31:0] engPushData = '0;
  logic        engPushOk, engPopOk, engFull, engEmpty;
  logic [31:0] engPopData;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  cmpHostIf i_cmpHostIf (
    .clk(clk), .rstN(rstN),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostAckN(hostAckN), .irq(irq),
    .engPush(engPush), .engPushData(engPushData), .engPushOk(engPushOk),
    .engPop(engPop), .engPopData(engPopData), .engPopOk(engPopOk),
    .engFull(engFull), .engEmpty(engEmpty)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // One host access; returns acknowledge seen after the first edge and read data.
  task automatic hostAccess(input logic isRd, input logic [1:0] addr, input logic [31:0] wd,
                            output logic ok, output logic [31:0] rd, output logic ackAfterRel);
    @(negedge clk);
    hostCsN = 1'b0; hostAddr = addr; hostWdata = wd;
    hostRdN = !isRd; hostWrN = isRd;
    @(negedge clk);
    ok = !hostAckN; rd = hostRdata;
    hostCsN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1;
    @(negedge clk);
    ackAfterRel = hostAckN;
  endtask

  task automatic hWr(input logic [1:0] addr, input logic [31:0] wd, output logic ok);
    logic [31:0] rd; logic rel;
    hostAccess(1'b0, addr, wd, ok, rd, rel);
  endtask

  task automatic hRd(input logic [1:0] addr, output logic [31:0] rd, output logic ok);
    logic rel;
    hostAccess(1'b1, addr, 32'h0, ok, rd, rel);
  endtask

  task automatic indWr(input logic [31:0] idx, input logic [31:0] wd);
    logic ok;
    hWr(A_PTR, idx, ok);
    hWr(A_WIN, wd, ok);
  endtask

  task automatic indRd(input logic [31:0] idx, output logic [31:0] rd);
    logic ok;
    hWr(A_PTR, idx, ok);
    hRd(A_WIN, rd, ok);
  endtask

  task automatic engPushWords(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      engPush = 1'b1; engPushData = base + 32'(i);
    end
    @(negedge clk);
    engPush = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    check("R6 reset ack high", {31'b0, hostAckN}, 32'h1);
    check("R11 reset irq low", {31'b0, irq}, 32'h0);
    check("R5 reset empty", {30'b0, engEmpty, engFull}, 32'h2);
  endtask

  task automatic tPointerAndWindow();
    logic [31:0] rd; logic ok, rel;
    hostAccess(1'b0, A_PTR, 32'h0000_0007, ok, rd, rel);
    check("R6 write acked", {31'b0, ok}, 32'h1);
    check("R6 ack released", {31'b0, rel}, 32'h1);
    hRd(A_PTR, rd, ok);
    check("R1 pointer readback", rd, 32'h7);
    hWr(A_WIN, 32'hCAFE_0007, ok);
    indWr(32'd12, 32'h1234_5678);
    indRd(32'd7, rd);
    check("R2 word 7 readback", rd, 32'hCAFE_0007);
    indRd(32'd12, rd);
    check("R2 word 12 readback", rd, 32'h1234_5678);
  endtask

  task automatic tOutOfRange();
    logic [31:0] rd;
    indWr(32'h0000_0017, 32'hDEAD_BEEF);   // index 16+7: must not alias word 7
    indRd(32'h0000_0017, rd);
    check("R3 out-of-range reads zero", rd, 32'h0);
    indRd(32'd7, rd);
    check("R3 word 7 untouched", rd, 32'hCAFE_0007);
    indRd(32'd0, rd);
    check("R4 threshold reset zero", rd, 32'h0);
  endtask

  task automatic tHostToEngine();
    logic ok;
    hWr(A_FIFO, 32'hA000_0001, ok);
    check("R5 host push acked", {31'b0, ok}, 32'h1);
    hWr(A_FIFO, 32'hA000_0002, ok);
    hWr(A_FIFO, 32'hA000_0003, ok);
    begin
      logic [31:0] rd;
      indWr(32'd1, 32'h0000_FFFF);           // read-only word
      indRd(32'd1, rd);
      check("R4 level reads 3, write ignored", rd, 32'd3);
    end
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check("R5 engine head order", engPopData, 32'hA000_0000 + 32'(i));
      check("R5 engine pop taken", {31'b0, engPopOk}, 32'h0);
      engPop = 1'b1;
      #0.1;
      check("R5 engine pop ok", {31'b0, engPopOk}, 32'h1);
      @(negedge clk);
      engPop = 1'b0;
    end
    @(negedge clk);
    check("R5 empty after drain", {31'b0, engEmpty}, 32'h1);
  endtask

  task automatic tEngineToHost();
    logic [31:0] rd; logic ok;
    engPushWords(3, 32'hB000_0010);
    for (int i = 0; i < 3; i++) begin
      hRd(A_FIFO, rd, ok);
      check("R5 host pop data", rd, 32'hB000_0010 + 32'(i));
      check("R6 host pop acked", {31'b0, ok}, 32'h1);
    end
  endtask

  task automatic tEmptyRead();
    logic [31:0] rd; logic ok;
    hRd(A_FIFO, rd, ok);
    check("R7 empty read not acked", {31'b0, ok}, 32'h0);
    engPushWords(1, 32'hC000_0001);
    hRd(A_FIFO, rd, ok);
    check("R7 order intact after empty read", rd, 32'hC000_0001);
    indRd(32'd1, rd);
    check("R7 level zero", rd, 32'h0);
  endtask

  task automatic tDualStrobe();
    logic [31:0] rd; logic ok;
    @(negedge clk);
    hostCsN = 1'b0; hostAddr = A_PTR; hostWdata = 32'h0000_0009;
    hostRdN = 1'b0; hostWrN = 1'b0;
    @(negedge clk);
    check("R12 dual strobe not acked", {31'b0, hostAckN}, 32'h1);
    hostCsN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1;
    @(negedge clk);
    hRd(A_PTR, rd, ok);
    check("R12 pointer unchanged", rd, 32'd1);
  endtask

  task automatic tThreshold();
    logic [31:0] rd; logic ok;
    indWr(32'd0, 32'd4);
    hWr(A_IRQ, 32'h0001_0000, ok);           // enable cause bit 0
    for (int i = 0; i < 3; i++) hWr(A_FIFO, 32'hD000_0000 + 32'(i), ok);
    @(negedge clk);
    check("R8 below threshold no irq", {31'b0, irq}, 32'h0);
    hWr(A_FIFO, 32'hD000_0003, ok);
    @(negedge clk);
    check("R11 irq at threshold", {31'b0, irq}, 32'h1);
    hRd(A_IRQ, rd, ok);
    check("R8 cause bit 0 set", rd, 32'h0001_0001);
    @(negedge clk); engPop = 1'b1; @(negedge clk); engPop = 1'b0;
    hWr(A_IRQ, 32'h0001_0001, ok);           // clear bit 0, keep enable
    @(negedge clk);
    check("R10 cleared irq low", {31'b0, irq}, 32'h0);
    hRd(A_IRQ, rd, ok);
    check("R10 cause cleared", rd, 32'h0001_0000);
    hWr(A_FIFO, 32'hD000_0004, ok);          // back to 4 words
    hWr(A_IRQ, 32'h0000_0000, ok);           // disable, clear nothing
    @(negedge clk);
    check("R11 masked irq low", {31'b0, irq}, 32'h0);
    hRd(A_IRQ, rd, ok);
    check("R10 zero write keeps cause", rd, 32'h0000_0001);
    indWr(32'd0, 32'd0);
    hWr(A_IRQ, 32'h0000_FFFF, ok);
    hRd(A_IRQ, rd, ok);
    check("R10 cleared with no set condition", rd, 32'h0);
    repeat (4) begin @(negedge clk); engPop = 1'b1; end
    @(negedge clk); engPop = 1'b0;
  endtask

  task automatic tFullAndOverflow();
    logic [31:0] rd; logic ok;
    engPushWords(DEPTH, 32'hE000_0000);
    check("R5 full flag", {31'b0, engFull}, 32'h1);
    @(negedge clk); engPush = 1'b1; engPushData = 32'hFFFF_FFFF;
    #0.1;
    check("R9 push refused when full", {31'b0, engPushOk}, 32'h0);
    @(negedge clk); engPush = 1'b0;
    hWr(A_FIFO, 32'h5555_5555, ok);
    check("R7 full write not acked", {31'b0, ok}, 32'h0);
    hRd(A_IRQ, rd, ok);
    check("R9 overflow cause", rd, 32'h0000_0002);
    indRd(32'd1, rd);
    check("R7 level stays 512", rd, 32'd512);
    @(negedge clk);
    check("R7 head unchanged", engPopData, 32'hE000_0000);
    hWr(A_IRQ, 32'h0002_0000, ok);           // enable overflow, no clear
    @(negedge clk);
    check("R11 overflow irq", {31'b0, irq}, 32'h1);
    hWr(A_IRQ, 32'h0000_0002, ok);
    @(negedge clk);
    check("R10 overflow cleared", {31'b0, irq}, 32'h0);
    engPop = 1'b1;
    for (int i = 0; i < DEPTH; i++) @(negedge clk);
    engPop = 1'b0;
    check("R5 drained", {31'b0, engEmpty}, 32'h1);
  endtask

  initial begin
    #100000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tPointerAndWindow();
    tOutOfRange();
    tHostToEngine();
    tEngineToHost();
    tEmptyRead();
    tDualStrobe();
    tThreshold();
    tFullAndOverflow();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule